// File: doc/BRIEF.md
# Serial ACIA with Register Map and Held Interrupt

A byte-wide serial adapter that sits on a synchronous processor bus. Four registers share a 2-bit address. Offset 0 is the data port: writes go to a transmit holding register and reads return the receive holding register. Offset 1 is read-only status, offset 2 is the command register and offset 3 is the control register. A byte written to the data port moves into a shift-out transmitter as soon as the shifter is idle. The receiver oversamples the line at 16x and deposits each completed byte in the receive holding register.

The bit rate comes from a 4-bit code in the control register. The code picks an entry from a 16-entry divisor table. The divisor counts periods of a reference clock, which arrives as a one-cycle enable `ref_en_i` in the `clk_i` domain. A second control bit can switch the receiver onto an external 16x tick.

The interrupt request is active low and is held as a level. It stays asserted until software services its cause: by reading the data port, by writing a new byte, or by masking the cause in the command register.

Top module: `serial_acia`

## Requirements
- R1: After reset `irq_no` is 1, `txd_o` is 1, status reads 0x10 and the command and control registers read 0x00.
- R2: A write to offset 2 or offset 3 is read back unchanged from the same offset.
- R3: The transmitter sends a frame LSB first. The frame is one start bit (0), then eight data bits, then one stop bit (1). Each bit lasts 16 baud ticks, and the line idles at 1.
- R4: Status bit 4 (transmit empty) reads 0 while a written byte waits in the holding register behind a busy shifter. It reads 1 again once the byte has moved into the shifter.
- R5: A received byte sets status bit 3 (receive full) and is returned by a read of offset 0. That read clears bit 3.
- R6: If a byte completes while bit 3 is still set, status bit 2 (overrun) becomes 1 and the unread byte is kept. A read of offset 0 returns the kept byte and clears bits 2 and 3.
- R7: Receive interrupt: when command bit 0 is 1, bit 1 is 0 and bits 3:2 are not 00, a full receive register drives `irq_no` low and sets status bit 7. Reading offset 0 releases `irq_no`.
- R8: Transmit interrupt: when command bit 0 is 1 and bits 3:2 are 01, an empty transmit register drives `irq_no` low, and writing a byte releases it. Command 0x0B masks both causes. Command 0x01 (bits 3:2 = 00) masks both causes.
- R9: Control bits 3:0 select how many reference periods make one 16x tick. Code 0x0 gives 1, code 0xD gives 16, code 0xE gives 12 (9600 baud from 1.8432 MHz) and code 0xF gives 6.
- R10: With control bit 4 at 0, the receiver takes its 16x tick from `ext_rx16_i`. With control bit 4 at 1, it uses the internal divider. The transmitter always uses the internal divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 1 | One-cycle pulse per reference clock period |
| ext_rx16_i | input | 1 | External 16x receive tick |
| cs_i | input | 1 | Chip select |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of a selected read |
| irq_no | output | 1 | Interrupt request, active low, level held |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |

## Verification
A register write takes effect at the edge that samples it. Read data is combinational in the select cycle, and the side effects of a data read (clearing receive full and overrun, releasing the interrupt) are visible one edge later. The bench drives each access on a falling edge and samples on the following falling edge. For transmit, the start bit falls one edge after the byte moves to the shifter, and the first bit can be short by up to one divisor period. The monitor therefore finds the falling edge and samples each bit half a bit time into it, and the span checks allow one divisor of slack. A received byte is flagged within one divisor plus three cycles of the middle of its stop bit, so the bench checks flags only after the full stop bit has been driven.

// File: rtl/acia_pkg.sv
package acia_pkg;
  localparam int DATA_W = 8;
  localparam int OVS    = 16;
  localparam int TK_W   = $clog2(OVS);
  localparam int BC_W   = $clog2(DATA_W + 2);
  localparam int DIV_W  = 12;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // reference periods per 16x tick
  function automatic logic [DIV_W-1:0] rate_div(input logic [3:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'h0: d = 12'd1;
      4'h1: d = 12'd2304;
      4'h2: d = 12'd1536;
      4'h3: d = 12'd1047;
      4'h4: d = 12'd856;
      4'h5: d = 12'd768;
      4'h6: d = 12'd384;
      4'h7: d = 12'd192;
      4'h8: d = 12'd96;
      4'h9: d = 12'd64;
      4'hA: d = 12'd48;
      4'hB: d = 12'd32;
      4'hC: d = 12'd24;
      4'hD: d = 12'd16;
      4'hE: d = 12'd12;
      default: d = 12'd6;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/acia_baud.sv
module acia_baud
  import acia_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_en_i,
  input  logic [3:0] code_i,
  output logic       tick_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div, cnt;
  logic             wrap;

  assign div    = rate_div(code_i);
  assign wrap   = (cnt >= div - ONE);
  assign tick_o = ref_en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt <= '0;
    else if (ref_en_i) cnt <= wrap ? '0 : cnt + ONE;
  end

  assert_tick_spacing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div != ONE) |=> (!tick_o || !$stable(code_i)));
endmodule

// File: rtl/acia_tx.sv
module acia_tx
  import acia_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              txd_o
);
  localparam int FRAME = DATA_W + 2;
  localparam logic [TK_W-1:0] TK_LAST  = TK_W'(OVS - 1);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(FRAME - 1);

  logic [FRAME-1:0] sh;
  logic [TK_W-1:0]  tk;
  logic [BC_W-1:0]  bc;
  logic             busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh   <= '1;
      tk   <= '0;
      bc   <= '0;
      busy <= 1'b0;
    end else if (load_i && !busy) begin
      sh   <= {1'b1, data_i, 1'b0};
      tk   <= '0;
      bc   <= '0;
      busy <= 1'b1;
    end else if (busy && tick_i) begin
      if (tk == TK_LAST) begin
        tk <= '0;
        sh <= {1'b1, sh[FRAME-1:1]};
        if (bc == BIT_LAST) busy <= 1'b0;
        else                bc   <= bc + 1'b1;
      end else begin
        tk <= tk + 1'b1;
      end
    end
  end

  assign ready_o = !busy;
  assign txd_o   = busy ? sh[0] : 1'b1;

  assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy) |=> !txd_o);
  assert_idle_mark_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && tick_i && tk == TK_LAST && bc == BIT_LAST) |=> txd_o);
endmodule

// File: rtl/acia_rx.sv
module acia_rx
  import acia_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [TK_W-1:0] TK_LAST  = TK_W'(OVS - 1);
  localparam logic [TK_W-1:0] TK_HALF  = TK_W'(OVS / 2 - 1);
  localparam logic [BC_W-1:0] STOP_IDX = BC_W'(DATA_W + 1);

  logic              s1, s2, busy;
  logic [TK_W-1:0]   tk;
  logic [BC_W-1:0]   bc;
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= 1'b1; s2 <= 1'b1;
      busy <= 1'b0; tk <= '0; bc <= '0; sh <= '0; done_o <= 1'b0;
    end else begin
      s1     <= rxd_i;
      s2     <= s1;
      done_o <= 1'b0;
      if (tick_i) begin
        if (!busy) begin
          if (!s2) begin
            busy <= 1'b1; tk <= '0; bc <= '0;
          end
        end else if (bc == '0) begin
          // mid start bit: reject glitches
          if (tk == TK_HALF) begin
            tk <= '0;
            if (s2) busy <= 1'b0;
            else    bc   <= bc + 1'b1;
          end else tk <= tk + 1'b1;
        end else if (tk == TK_LAST) begin
          tk <= '0;
          if (bc == STOP_IDX) begin
            busy   <= 1'b0;
            done_o <= s2;
          end else begin
            sh <= {s2, sh[DATA_W-1:1]};
            bc <= bc + 1'b1;
          end
        end else tk <= tk + 1'b1;
      end
    end
  end

  assign data_o = sh;

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/serial_acia.sv
module serial_acia
  import acia_pkg::*;
#(
  parameter bit RX_EXT_CLK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_en_i,
  input  logic              ext_rx16_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no,
  output logic              txd_o,
  input  logic              rxd_i
);
  reg_sel_e          sel;
  logic              wr_data, rd_data, wr_cmd, wr_ctrl;
  logic [DATA_W-1:0] thr, rbr, cmd_q, ctrl_q, status;
  logic              thr_full, rx_full, ovr;
  logic              tick_int, rx_tick, tx_ready, rx_done;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_ie, tx_ie, irq;

  assign sel     = reg_sel_e'(addr_i);
  assign wr_data = cs_i &&  we_i && sel == SEL_DATA;
  assign rd_data = cs_i && !we_i && sel == SEL_DATA;
  assign wr_cmd  = cs_i &&  we_i && sel == SEL_CMD;
  assign wr_ctrl = cs_i &&  we_i && sel == SEL_CTRL;

  acia_baud u_baud (
    .clk_i, .rst_ni, .ref_en_i, .code_i(ctrl_q[3:0]), .tick_o(tick_int)
  );

  if (RX_EXT_CLK) begin : g_rx_sel
    assign rx_tick = ctrl_q[4] ? tick_int : ext_rx16_i;
  end else begin : g_rx_int
    assign rx_tick = tick_int;
  end

  acia_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick_int), .load_i(thr_full), .data_i(thr),
    .ready_o(tx_ready), .txd_o
  );

  acia_rx u_rx (
    .clk_i, .rst_ni, .tick_i(rx_tick), .rxd_i, .done_o(rx_done), .data_o(rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0; ctrl_q <= '0; thr <= '0; rbr <= '0;
      thr_full <= 1'b0; rx_full <= 1'b0; ovr <= 1'b0;
    end else begin
      if (wr_cmd)  cmd_q  <= wdata_i;
      if (wr_ctrl) ctrl_q <= wdata_i;
      if (wr_data) begin
        thr      <= wdata_i;
        thr_full <= 1'b1;
      end else if (thr_full && tx_ready) begin
        thr_full <= 1'b0;
      end
      if (rx_done) begin
        if (rx_full && !rd_data) begin
          ovr <= 1'b1;             // keep the unread byte
        end else begin
          rbr     <= rx_byte;
          rx_full <= 1'b1;
          ovr     <= 1'b0;
        end
      end else if (rd_data) begin
        rx_full <= 1'b0;
        ovr     <= 1'b0;
      end
    end
  end

  // bits 3:2 = 00 masks everything
  assign rx_ie  = !cmd_q[1] && cmd_q[3:2] != 2'b00;
  assign tx_ie  = cmd_q[3:2] == 2'b01;
  assign irq    = cmd_q[0] && ((rx_ie && rx_full) || (tx_ie && !thr_full));
  assign irq_no = !irq;
  assign status = {irq, 2'b00, !thr_full, rx_full, ovr, 2'b00};

  always_comb begin
    rdata_o = '0;
    if (cs_i && !we_i) begin
      case (sel)
        SEL_DATA: rdata_o = rbr;
        SEL_STAT: rdata_o = status;
        SEL_CMD:  rdata_o = cmd_q;
        default:  rdata_o = ctrl_q;
      endcase
    end
  end

  assert_thr_drains_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_full && tx_ready && !wr_data) |=> !thr_full);
  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !rx_done) |=> (!rx_full && !ovr));
  assert_overrun_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_full && !rd_data) |=> (ovr && $stable(rbr)));
  assert_rx_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && !rx_full && cmd_q[0] && rx_ie && !wr_cmd) |=> !irq_no);
  assert_write_releases_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !tx_ready && !wr_cmd && !rx_full && !rx_done) |=> irq_no);
endmodule

// File: tb/tb_serial_acia.sv
module tb_serial_acia;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b1;
  logic       ext_tick = 1'b0;
  logic       cs = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_n, txd;
  logic       rxd = 1'b1;

  int n_run = 0, n_fail = 0;
  int bit_cyc = 96;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  serial_acia dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_en_i(ref_en), .ext_rx16_i(ext_tick),
    .cs_i(cs), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_no(irq_n), .txd_o(txd), .rxd_i(rxd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic send_tx(input logic [7:0] b);
    exp_q.push_back(b);
    bus_wr(2'd0, b);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (bit_cyc) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] b, input int bc);
    @(negedge clk); rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bc) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (bc + 4) @(negedge clk);
  endtask

  task automatic measure_zero(input int div, input string req);
    int len;
    bit_cyc = 16 * div;
    send_tx(8'h00);
    while (txd !== 1'b0) @(negedge clk);
    len = 0;
    while (txd === 1'b0) begin @(negedge clk); len++; end
    chk(req, 32'(len >= 9 * bit_cyc - div && len <= 9 * bit_cyc + 1), 32'd1);
    wait_drain();
  endtask

  // ext 16x tick every 4 cycles
  initial begin : ext_gen
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % 4;
      ext_tick = (c == 0);
    end
  end

  // scoreboard monitor for the serial line (R3)
  initial begin : mon
    logic [7:0] got;
    logic [7:0] exp;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        repeat (bit_cyc / 2) @(negedge clk);
        chk("R3 start bit", 32'(txd), 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (bit_cyc) @(negedge clk);
          got[i] = txd;
        end
        repeat (bit_cyc) @(negedge clk);
        chk("R3 stop bit", 32'(txd), 32'd1);
        if (exp_q.size() == 0) begin
          chk("R3 unexpected frame", 32'(got), 32'hFFFF_FFFF);
        end else begin
          exp = exp_q.pop_front();
          chk("R3 frame data", 32'(got), 32'(exp));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1
    chk("R1 irq idle", 32'(irq_n), 32'd1);
    chk("R1 txd idle", 32'(txd), 32'd1);
    bus_rd(2'd1, d); chk("R1 status", 32'(d), 32'h10);
    bus_rd(2'd2, d); chk("R1 cmd", 32'(d), 32'h00);
    bus_rd(2'd3, d); chk("R1 ctrl", 32'(d), 32'h00);

    // R2
    bus_wr(2'd3, 8'h1F); bus_rd(2'd3, d); chk("R2 ctrl readback", 32'(d), 32'h1F);
    bus_wr(2'd2, 8'h0B); bus_rd(2'd2, d); chk("R2 cmd readback", 32'(d), 32'h0B);
    chk("R8 0x0B masks tx empty", 32'(irq_n), 32'd1);

    // R3, R4 at code F
    bit_cyc = 96;
    send_tx(8'hA5);
    send_tx(8'h3C);
    bus_rd(2'd1, d); chk("R4 holding full", 32'(d & 8'h10), 32'h00);
    wait_drain();
    bus_rd(2'd1, d); chk("R4 empty again", 32'(d & 8'h10), 32'h10);
    send_tx(8'hFF);
    wait_drain();
    send_tx(8'h01);
    wait_drain();

    // R9 divisor table
    bus_wr(2'd3, 8'h1E); measure_zero(12, "R9 code E span");
    bus_wr(2'd3, 8'h1D); measure_zero(16, "R9 code D span");
    bus_wr(2'd3, 8'h10); measure_zero(1, "R9 code 0 span");
    bus_wr(2'd3, 8'h1F); bit_cyc = 96;

    // R5
    rx_send(8'h5A, 96);
    bus_rd(2'd1, d); chk("R5 rx full", 32'(d), 32'h18);
    chk("R8 0x0B masks rx", 32'(irq_n), 32'd1);
    bus_rd(2'd0, d); chk("R5 rx data", 32'(d), 32'h5A);
    bus_rd(2'd1, d); chk("R5 cleared", 32'(d), 32'h10);

    // R6
    rx_send(8'h11, 96);
    rx_send(8'h22, 96);
    bus_rd(2'd1, d); chk("R6 overrun flag", 32'(d), 32'h1C);
    bus_rd(2'd0, d); chk("R6 kept byte", 32'(d), 32'h11);
    bus_rd(2'd1, d); chk("R6 cleared", 32'(d), 32'h10);

    // R7
    bus_wr(2'd2, 8'h09);
    chk("R7 no cause", 32'(irq_n), 32'd1);
    rx_send(8'hC3, 96);
    chk("R7 irq low", 32'(irq_n), 32'd0);
    bus_rd(2'd1, d); chk("R7 status irq", 32'(d), 32'h98);
    bus_rd(2'd0, d); chk("R7 data", 32'(d), 32'hC3);
    chk("R7 irq released", 32'(irq_n), 32'd1);

    // R8
    bus_wr(2'd2, 8'h05);
    chk("R8 tx empty irq", 32'(irq_n), 32'd0);
    bus_rd(2'd1, d); chk("R8 status", 32'(d), 32'h90);
    send_tx(8'h81);
    send_tx(8'h7E);
    chk("R8 write releases", 32'(irq_n), 32'd1);
    wait_drain();
    chk("R8 empty reasserts", 32'(irq_n), 32'd0);
    bus_wr(2'd2, 8'h01);
    chk("R8 quiet tx", 32'(irq_n), 32'd1);
    rx_send(8'h44, 96);
    chk("R8 quiet rx", 32'(irq_n), 32'd1);
    bus_rd(2'd0, d); chk("R8 quiet data", 32'(d), 32'h44);

    // R10 external receive tick, 64 cycles per bit
    bus_wr(2'd3, 8'h0F);
    rx_send(8'h96, 64);
    bus_rd(2'd1, d); chk("R10 ext rx full", 32'(d & 8'h08), 32'h08);
    bus_rd(2'd0, d); chk("R10 ext rx data", 32'(d), 32'h96);
    send_tx(8'h5E);
    wait_drain();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule